// File: doc/BRIEF.md
# Chainable Streaming Read Front End

This block sits in front of a word-organised memory array and serves two kinds of traffic. In normal mode a host presents an address with chip enable and a write strobe on a rising clock edge, and the block performs one read or one write at that location. In streaming mode an internal address counter replaces the host address, and the block becomes read-only. It delivers one location per qualified clock edge and walks through the whole array.

Several of these blocks can be chained to form one long read stream. Each stage waits for a permission input from its predecessor. Once it has read its own last location, it raises a hand-off output that grants the next stage permission. A pair of control inputs, a start level and a stop level, hold the counter at zero when deasserted or asserted respectively. The array can be viewed either as full-width words or as bytes. In byte view the address gains one extra significant bit.

The data bus is modelled as separate input, output and per-bit drive-enable vectors. A small behavioural array stands in for the storage cells.

Top module: `aictr_top`

## Requirements
- R1: In normal mode (stream enable low), chip enable low with write strobe low at a rising edge reads the addressed location. The read data is on `dq_out` from that edge onward. During the clock-high half that follows the edge, it is driven whenever `oe` is high.
- R2: Chip enable high at a rising edge performs no access, even with the write strobe high, and leaves the array unchanged. `dq_oe` is all zero for the whole following cycle.
- R3: In normal mode, chip enable low with write strobe high at a rising edge writes `dq_in` into the addressed location. `dq_oe` is all zero for the whole following cycle.
- R4: After a normal-mode read, `dq_oe` is zero while `oe` is low and zero during the clock-low half of the cycle.
- R5: With stream enable high at a rising edge, the address comes from the internal counter, not from `addr`, and the write strobe has no effect on the array. Each qualified edge reads the counter's location and then advances the counter by one.
- R6: A streaming edge is qualified only when chip enable is low, start is 1, stop is 0, permission-in is 1 and the hand-off output is low. In any other streaming cycle no read occurs, the counter holds, and `dq_oe` stays zero.
- R7: At any rising edge with stream enable high and either start low or stop high, the counter returns to zero and the hand-off output clears.
- R8: The edge that reads the last address sets the hand-off output high. The last address is 2^(ADDR_W-1)-1 in word view and 2^ADDR_W-1 in byte view. After that edge the counter holds, and later qualified-looking cycles perform no read, until a clear.
- R9: After a streaming read, every data bit in use is driven while chip enable is low, and nothing is driven while chip enable is high. This holds in both clock halves and is independent of `oe`.
- R10: In word view (`byte_mode` = 0), address bit ADDR_W-1 is ignored and all 16 data bits are used. In byte view, address bit ADDR_W-1 picks the byte of word `addr[ADDR_W-2:0]`: 1 selects bits 15:8 and 0 selects bits 7:0. In byte view the byte travels on data bits 7:0, and bits 15:8 are never driven.
- R11: While reset is asserted and after its release, `dq_oe` is zero, the hand-off output is low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| we | input | 1 | Write strobe (normal mode only) |
| oe | input | 1 | Output enable for normal-mode reads |
| addr | input | ADDR_W | Host address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 16 | Per-bit bus drive enable |
| byte_mode | input | 1 | 1 = byte view, 0 = word view |
| ai_en | input | 1 | Streaming mode select |
| ai_init | input | 1 | Start level; low clears the counter |
| ai_done | input | 1 | Stop level; high clears the counter |
| ovf_in | input | 1 | Permission from the previous chain stage |
| ovf_out | output | 1 | Hand-off to the next chain stage |

## Verification
Every access takes effect at the rising edge where it is sampled. Read data and the hand-off output are therefore due from that edge onward, and the bus drive state then follows the clock phase, `oe` and chip enable within the same cycle.

The bench drives its inputs in the clock-low half. It advances a behavioural model at each edge and then compares results twice per cycle: 1 ns after the edge, in the high half, and 3 ns after the edge, in the low half. This way both the phase-dependent and the phase-independent drive rules are checked against the access that produced them. A write is confirmed by a later read, and an ignored write strobe is confirmed by reading the same location back in normal mode.

// File: rtl/aictr_pkg.sv
`timescale 1ns/1ps
package aictr_pkg;
  // Kind of access performed at a rising edge.
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_READ   = 2'd1,
    ACC_WRITE  = 2'd2,
    ACC_STREAM = 2'd3
  } acc_e;
endpackage

// File: rtl/aictr_decode.sv
`timescale 1ns/1ps
module aictr_decode
  import aictr_pkg::*;
(
  input  logic ce_n,
  input  logic we,
  input  logic ai_en,
  input  logic ai_init,
  input  logic ai_done,
  input  logic ovf_in,
  input  logic ovf_held,
  output acc_e acc,
  output logic ctr_clr
);
  // Classify the cycle; clearing has priority over any streaming read.
  always_comb begin
    acc     = ACC_NONE;
    ctr_clr = 1'b0;
    if (ai_en) begin
      if (!ai_init || ai_done) begin
        ctr_clr = 1'b1;
      end else if (!ce_n && ovf_in && !ovf_held) begin
        acc = ACC_STREAM;
      end
    end else if (!ce_n) begin
      acc = we ? ACC_WRITE : ACC_READ;
    end
  end
endmodule

// File: rtl/aictr_counter.sv
`timescale 1ns/1ps
module aictr_counter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              byte_mode,
  output logic [ADDR_W-1:0] cnt_q,
  output logic              ovf_q
);
  localparam logic [ADDR_W-1:0] LAST_BYTE = '1;
  localparam logic [ADDR_W-1:0] LAST_WORD = {1'b0, {(ADDR_W-1){1'b1}}};

  logic [ADDR_W-1:0] last_addr;
  logic              at_last;
  logic [ADDR_W-1:0] cnt_d;
  logic              ovf_d;
  logic              upd_en;

  always_comb begin
    last_addr = byte_mode ? LAST_BYTE : LAST_WORD;
    at_last   = (cnt_q == last_addr);
    upd_en    = clr | adv;
    cnt_d     = cnt_q;
    ovf_d     = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (adv) begin
      if (at_last) ovf_d = 1'b1;
      else         cnt_d = cnt_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !ovf_q); // R7
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !at_last) |=> cnt_q == ADDR_W'($past(cnt_q) + ADDR_W'(1))); // R5
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> $stable(cnt_q) && ovf_q); // R8
  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(adv)); // R8
endmodule

// File: rtl/aictr_mem.sv
`timescale 1ns/1ps
module aictr_mem #(
  parameter int IDX_W = 7,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LANES-1:0]   wr_lane,
  input  logic [IDX_W-1:0]   idx,
  input  logic [8*LANES-1:0] wr_data,
  input  logic               rd_en,
  output logic [8*LANES-1:0] rd_data_q
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int DATA_W = 8 * LANES;

  logic [DATA_W-1:0] store [DEPTH];

  // Behavioural storage with per-byte write enables.
  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES; g++) begin
      if (wr_en && wr_lane[g]) store[idx][g*8 +: 8] <= wr_data[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= store[idx];
  end
endmodule

// File: rtl/aictr_top.sv
`timescale 1ns/1ps
module aictr_top
  import aictr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  input  logic              byte_mode,
  input  logic              ai_en,
  input  logic              ai_init,
  input  logic              ai_done,
  input  logic              ovf_in,
  output logic              ovf_out
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int LANES  = 2;
  localparam int DATA_W = 8 * LANES;

  acc_e              acc;
  logic              ctr_clr;
  logic [ADDR_W-1:0] cnt_q;
  logic              ovf_q;
  logic [ADDR_W-1:0] eff_addr;
  logic              hi_sel;
  logic [LANES-1:0]  wr_lane;
  logic [DATA_W-1:0] wr_data;
  logic              rd_en;
  logic              wr_en;
  logic [DATA_W-1:0] rd_word;

  // Output-side state describing the access of the last edge.
  logic norm_q, strm_q, byte_q, lane_q;
  logic norm_d, strm_d;
  logic drive;

  aictr_decode u_decode (
    .ce_n     (ce_n),
    .we       (we),
    .ai_en    (ai_en),
    .ai_init  (ai_init),
    .ai_done  (ai_done),
    .ovf_in   (ovf_in),
    .ovf_held (ovf_q),
    .acc      (acc),
    .ctr_clr  (ctr_clr)
  );

  aictr_counter #(.ADDR_W(ADDR_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctr_clr),
    .adv       (acc == ACC_STREAM),
    .byte_mode (byte_mode),
    .cnt_q     (cnt_q),
    .ovf_q     (ovf_q)
  );

  always_comb begin
    eff_addr = ai_en ? cnt_q : addr;
    hi_sel   = eff_addr[ADDR_W-1];
    rd_en    = (acc == ACC_READ) || (acc == ACC_STREAM);
    wr_en    = (acc == ACC_WRITE);
    if (byte_mode) begin
      wr_lane = hi_sel ? 2'b10 : 2'b01;
      wr_data = {dq_in[7:0], dq_in[7:0]};
    end else begin
      wr_lane = '1;
      wr_data = dq_in;
    end
    norm_d = (acc == ACC_READ);
    strm_d = (acc == ACC_STREAM);
  end

  aictr_mem #(.IDX_W(IDX_W), .LANES(LANES)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_lane   (wr_lane),
    .idx       (eff_addr[IDX_W-1:0]),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data_q (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= 1'b0;
      strm_q <= 1'b0;
      byte_q <= 1'b0;
      lane_q <= 1'b0;
    end else begin
      norm_q <= norm_d;
      strm_q <= strm_d;
      if (rd_en) begin
        byte_q <= byte_mode;
        lane_q <= hi_sel;
      end
    end
  end

  // Streaming drive follows chip enable; normal drive follows clock phase and oe.
  always_comb begin
    drive   = strm_q ? !ce_n : (norm_q && clk && oe);
    dq_out  = byte_q ? {8'h00, (lane_q ? rd_word[15:8] : rd_word[7:0])} : rd_word;
    ovf_out = ovf_q;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_oe
    if (g == 0) begin : g_low
      assign dq_oe[7:0] = {8{drive}};
    end else begin : g_high
      assign dq_oe[g*8 +: 8] = {8{drive && !byte_q}};
    end
  end

  AST_CE_NOACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (acc == ACC_NONE)); // R2
  AST_STREAM_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ai_en |-> !wr_en); // R5
  AST_STREAM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_STREAM) |-> (ai_init && !ai_done && ovf_in && !ovf_out && !ce_n)); // R6
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !norm_q && !strm_q); // R3
endmodule

// File: tb/tb_aictr_top.sv
`timescale 1ns/1ps
module tb_aictr_top;
  localparam int AW = 8;
  localparam int NW = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we, oe, byte_mode, ai_en, ai_init, ai_done, ovf_in;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in;
  logic [15:0]   dq_out, dq_oe;
  logic          ovf_out;

  always #2 clk = ~clk;

  aictr_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we(we), .oe(oe), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .byte_mode(byte_mode),
    .ai_en(ai_en), .ai_init(ai_init), .ai_done(ai_done), .ovf_in(ovf_in),
    .ovf_out(ovf_out)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  int ref_mem [NW];
  int ref_cnt = 0;
  int ref_ovf = 0;
  int ref_kind = 0;   // 0 none, 1 normal read, 2 streamed read
  int ref_data = 0;
  int ref_mask = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model_read(int a);
    int w;
    w = ref_mem[a & (NW - 1)];
    if (byte_mode) begin
      ref_mask = 'h00FF;
      ref_data = ((a >> (AW - 1)) & 1) != 0 ? (w >> 8) & 'hFF : w & 'hFF;
    end else begin
      ref_mask = 'hFFFF;
      ref_data = w;
    end
  endfunction

  function automatic void model_step();
    int last;
    int i;
    last = byte_mode ? (1 << AW) - 1 : NW - 1;
    ref_kind = 0;
    if (ai_en) begin
      if (!ai_init || ai_done) begin
        ref_cnt = 0;
        ref_ovf = 0;
      end else if (!ce_n && ovf_in && ref_ovf == 0) begin
        model_read(ref_cnt);
        ref_kind = 2;
        if (ref_cnt == last) ref_ovf = 1;
        else ref_cnt = ref_cnt + 1;
      end
    end else if (!ce_n) begin
      if (we) begin
        i = int'(addr) & (NW - 1);
        if (byte_mode) begin
          if (addr[AW-1]) ref_mem[i] = (ref_mem[i] & 'h00FF) | ((int'(dq_in) & 'hFF) << 8);
          else            ref_mem[i] = (ref_mem[i] & 'hFF00) | (int'(dq_in) & 'hFF);
        end else begin
          ref_mem[i] = int'(dq_in);
        end
      end else begin
        model_read(int'(addr));
        ref_kind = 1;
      end
    end
  endfunction

  task automatic cyc(string req, logic c, logic w, logic o, int a, int d,
                     logic ai, logic ini, logic dn, logic oi);
    int exp_hi;
    int exp_lo;
    ce_n = c; we = w; oe = o; addr = AW'(a); dq_in = 16'(d);
    ai_en = ai; ai_init = ini; ai_done = dn; ovf_in = oi;
    @(posedge clk);
    model_step();
    exp_hi = (ref_kind == 2) ? (ce_n ? 0 : ref_mask) :
             (ref_kind == 1) ? (oe ? ref_mask : 0) : 0;
    exp_lo = (ref_kind == 2) ? (ce_n ? 0 : ref_mask) : 0;
    #1;
    chk(req, "ovf_out", int'(ovf_out), ref_ovf);
    chk(req, "dq_oe(high)", int'(dq_oe), exp_hi);
    if (exp_hi != 0) chk(req, "dq_out", int'(dq_out) & exp_hi, ref_data & exp_hi);
    #2;
    chk(req, "dq_oe(low)", int'(dq_oe), exp_lo);
  endtask

  task automatic nwrite(string req, int a, int d);
    cyc(req, 0, 1, 1, a, d, 0, 1, 0, 1);
  endtask
  task automatic nread(string req, int a, logic o);
    cyc(req, 0, 0, o, a, 0, 0, 1, 0, 1);
  endtask
  task automatic sclear(string req);
    cyc(req, 0, 0, 1, 0, 0, 1, 0, 0, 1);
  endtask
  task automatic stream(string req, logic c, logic w, logic o, logic oi);
    cyc(req, c, w, o, 0, 'hFFFF, 1, 1, 0, oi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we = 1'b0; oe = 1'b0; addr = '0; dq_in = '0;
    byte_mode = 1'b0; ai_en = 1'b0; ai_init = 1'b1; ai_done = 1'b0; ovf_in = 1'b0;
    for (int i = 0; i < NW; i++) ref_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "dq_oe in reset", int'(dq_oe), 0);
    chk("R11", "ovf_out in reset", int'(ovf_out), 0);
    rst_n = 1'b1;
    #2;

    // R3: fill the array with distinct words
    for (int i = 0; i < NW; i++) nwrite("R3", i, (i * 613 + 17) & 'hFFFF);

    // R11: counter starts at zero after reset, first streamed read is location 0
    for (int i = 0; i < 3; i++) stream("R11", 0, 0, 1, 1);

    // R1: normal reads; R4: oe low keeps the bus released
    for (int i = 0; i < NW; i += 7) nread("R1", i, 1);
    for (int i = 1; i < NW; i += 19) nread("R4", i, 0);

    // R2: disabled write has no effect
    cyc("R2", 1, 1, 1, 3, 'hDEAD, 0, 1, 0, 1);
    nread("R2", 3, 1);

    // R10: word view ignores the top address bit
    nwrite("R10", (1 << (AW - 1)) | 5, 'hBEEF);
    nread("R10", 5, 1);
    nread("R10", (1 << (AW - 1)) | 5, 1);

    // R10: byte view lane selection
    byte_mode = 1'b1;
    nwrite("R10", 10, 'h11);
    nwrite("R10", (1 << (AW - 1)) | 10, 'h22);
    nread("R10", 10, 1);
    nread("R10", (1 << (AW - 1)) | 10, 1);
    byte_mode = 1'b0;
    nread("R10", 10, 1);

    // R7: clear, then R5/R9 streaming with oe toggling and ignored writes
    sclear("R7");
    for (int i = 0; i < 12; i++) stream("R9", 0, i % 3 == 0, i % 2 == 0, 1);
    for (int i = 0; i < 12; i++) nread("R5", i, 1);

    // R6: unqualified streaming cycles
    sclear("R7");
    stream("R6", 0, 0, 1, 1);
    stream("R6", 0, 0, 1, 0);
    stream("R6", 1, 0, 1, 1);
    stream("R9", 0, 0, 0, 1);
    cyc("R7", 0, 0, 1, 0, 0, 1, 1, 1, 1);
    stream("R6", 0, 0, 1, 1);

    // R8: run to the last word and beyond
    sclear("R7");
    for (int i = 0; i < NW + 4; i++) stream("R8", 0, 0, 1, 1);
    sclear("R7");
    stream("R8", 0, 0, 1, 1);

    // R10/R8: full byte-view stream
    byte_mode = 1'b1;
    sclear("R7");
    for (int i = 0; i < (1 << AW) + 3; i++) stream("R10", 0, 0, 1, 1);
    sclear("R7");
    byte_mode = 1'b0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule